// File: doc/BRIEF.md
# Nine-Bit Bus Word Assembler

This block receives the host side of a display controller's parallel bus when the bus runs at nine bits. Every 18-bit unit is a 6-6-6 pixel, a command or a parameter. It arrives as two nine-bit bus writes on the upper data lines. Each write is qualified by an active-low write strobe, and a register-select line marks it as instruction or data. Both strobes are synchronised into the system clock. One phase bit tracks whether the next bus cycle carries the upper or the lower half. When the lower half arrives, the block emits the joined 18-bit word with its register-select tag. On reads the same phase bit chooses which half of an 18-bit read-back word is driven onto the nine-bit output.

Noise can make host and block disagree about which half comes next. To recover, the host writes the all-zero instruction four times in a row. The block counts such writes and, on the fourth, forces the phase back to the upper half. The host must do this once after reset, and may repeat it at any time. An assembled instruction word that is entirely zero is treated as part of this sequence and is never forwarded.

Top module: `nine_bit_bus_rx`

## Requirements
- R1: During and after reset (`rst_n` low, asynchronous), `word_valid` is 0 and `bus_dout` is 0; the next bus cycle is an upper half and the zero-write run count is 0.
- R2: The first write of a pair supplies bits 17..9 of `word_data`, and the second supplies bits 8..0. For a pixel this puts red[5:0] and green[5:3] in the first write and green[2:0] and blue[5:0] in the second.
- R3: Each assembled word is presented with `word_valid` high for exactly one clock cycle. `word_is_data` carries the `bus_rs` value of the second write (1 = data, 0 = instruction).
- R4: A write taken as an upper half produces no output pulse; a pulse follows only the completing lower half.
- R5: The fourth consecutive write with `bus_rs`=0 and `bus_din`=0 forces the following bus cycle to be treated as an upper half, whatever the phase was before. That write itself contributes no data.
- R6: Any write with `bus_rs`=1 or a nonzero `bus_din` clears the zero-write run, so three zeros followed by such a write do not resynchronise.
- R7: A read cycle clears the zero-write run.
- R8: A word whose two halves were both zero instruction writes is not presented (no `word_valid` pulse).
- R9: A read taken in the upper phase drives `rd_word[17:9]` onto `bus_dout` and captures `rd_word`. The following read drives bits 8..0 of that captured word, even if `rd_word` has changed in between.
- R10: Reads advance the same phase bit as writes, so a single read shifts which write is taken as the upper half.
- R11: `bus_din` and `bus_rs` are taken once per rising edge of `bus_wr_n`, and a read half is driven once per falling edge of `bus_rd_n`. Each edge is acted on exactly once, however long the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_n | input | 1 | Active-low write strobe (asynchronous) |
| bus_rd_n | input | 1 | Active-low read strobe (asynchronous) |
| bus_rs | input | 1 | Register select: 0 instruction, 1 data |
| bus_din | input | 9 | Nine-bit write data from the upper bus lines |
| bus_dout | output | 9 | Nine-bit read data half |
| rd_word | input | 18 | Read-back word to be split into halves |
| word_valid | output | 1 | One-cycle pulse: assembled word available |
| word_data | output | 18 | Assembled 18-bit word |
| word_is_data | output | 1 | Register-select tag of the assembled word |

## Verification
The bench deliberately knocks the phase out of step by writing one stray half, then sends the four-zero sequence. A design that skipped the resync would pair every later write wrongly and produce shifted words. The zero run is broken once by a data write and once by a read; a design that failed to clear the run on either would resynchronise when it should not, and the word that follows would come out split differently from the expected one. The read path changes `rd_word` between the two halves, so a design that reread the live input instead of the captured word would drive the wrong lower half. A write with a very long low strobe catches a design that acts on the level instead of the edge, which would take the same half twice.

// File: rtl/nb_bus_pkg.sv
package nb_bus_pkg;
    typedef enum logic {
        PH_UPPER = 1'b0,
        PH_LOWER = 1'b1
    } phase_e;
endpackage

// File: rtl/bus_strobe_sync.sv
module bus_strobe_sync #(
    parameter int STAGES    = 2,
    parameter bit EDGE_RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic edge_ev
);
    localparam int SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic cur, prev;

    always_comb begin
        st_d.sh = {st_q.sh[SH_W-2:0], strobe_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: '1};
        else        st_q <= st_d;
    end

    assign cur  = st_q.sh[STAGES-1];
    assign prev = st_q.sh[STAGES];

    generate
        if (EDGE_RISE) begin : g_rise
            assign edge_ev = cur & ~prev;
        end else begin : g_fall
            assign edge_ev = ~cur & prev;
        end
    endgenerate

    // R11: one strobe edge yields a single-cycle event
    p_edge_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ev |=> !edge_ev);
endmodule

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
    parameter int RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ev,
    input  logic rd_ev,
    input  logic is_zero_cmd,
    output logic sync_hit
);
    localparam int CW = $clog2(RUN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        sync_hit = wr_ev && is_zero_cmd && (st_q.cnt == CW'(RUN - 1));
        if (rd_ev || (wr_ev && !is_zero_cmd)) begin
            st_d.cnt = '0;
        end else if (wr_ev) begin
            st_d.cnt = sync_hit ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(RUN));
    p_nonzero_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev && !is_zero_cmd) |=> st_q.cnt == '0);
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ev |=> st_q.cnt == '0);
endmodule

// File: rtl/half_assembler.sv
module half_assembler
    import nb_bus_pkg::*;
#(
    parameter int HALF_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_ev,
    input  logic                  sync_hit,
    input  phase_e                phase,
    input  logic [HALF_W-1:0]     din,
    input  logic                  rs,
    output logic                  word_valid,
    output logic [2*HALF_W-1:0]   word_data,
    output logic                  word_is_data
);
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] upper;
        logic              upper_rs;
        logic              valid;
        logic [WORD_W-1:0] word;
        logic              tag;
    } asm_state_t;

    asm_state_t st_d, st_q;
    logic all_zero_cmd;

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        all_zero_cmd = (st_q.upper == '0) && !st_q.upper_rs && (din == '0) && !rs;
        if (wr_ev && !sync_hit) begin
            if (phase == PH_UPPER) begin
                st_d.upper    = din;
                st_d.upper_rs = rs;
            end else if (!all_zero_cmd) begin
                st_d.valid = 1'b1;
                st_d.word  = {st_q.upper, din};
                st_d.tag   = rs;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_valid   = st_q.valid;
    assign word_data    = st_q.word;
    assign word_is_data = st_q.tag;

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    p_upper_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev && phase == PH_UPPER) |=> !word_valid);
    p_sync_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev && sync_hit) |=> !word_valid);
endmodule

// File: rtl/nine_bit_bus_rx.sv
module nine_bit_bus_rx
    import nb_bus_pkg::*;
#(
    parameter int HALF_W      = 9,
    parameter int SYNC_RUN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_n,
    input  logic                bus_rd_n,
    input  logic                bus_rs,
    input  logic [HALF_W-1:0]   bus_din,
    output logic [HALF_W-1:0]   bus_dout,
    input  logic [2*HALF_W-1:0] rd_word,
    output logic                word_valid,
    output logic [2*HALF_W-1:0] word_data,
    output logic                word_is_data
);
    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        phase_e            phase;
        logic [WORD_W-1:0] rd_hold;
        logic [HALF_W-1:0] dout;
    } top_state_t;

    top_state_t st_d, st_q;
    logic [1:0] strobe_n;
    logic [1:0] ev;
    logic wr_ev, rd_ev, sync_hit, is_zero_cmd;

    assign strobe_n = {bus_rd_n, bus_wr_n};

    generate
        for (genvar i = 0; i < 2; i++) begin : g_strobe
            bus_strobe_sync #(
                .STAGES    (SYNC_STAGES),
                .EDGE_RISE (i == 0)
            ) i_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .strobe_n (strobe_n[i]),
                .edge_ev  (ev[i])
            );
        end
    endgenerate

    assign wr_ev       = ev[0];
    assign rd_ev       = ev[1];
    assign is_zero_cmd = !bus_rs && (bus_din == '0);

    zero_run_detect #(.RUN(SYNC_RUN)) i_zero (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ev       (wr_ev),
        .rd_ev       (rd_ev),
        .is_zero_cmd (is_zero_cmd),
        .sync_hit    (sync_hit)
    );

    half_assembler #(.HALF_W(HALF_W)) i_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ev        (wr_ev),
        .sync_hit     (sync_hit),
        .phase        (st_q.phase),
        .din          (bus_din),
        .rs           (bus_rs),
        .word_valid   (word_valid),
        .word_data    (word_data),
        .word_is_data (word_is_data)
    );

    always_comb begin
        st_d = st_q;
        if (rd_ev) begin
            if (st_q.phase == PH_UPPER) begin
                st_d.dout    = rd_word[WORD_W-1:HALF_W];
                st_d.rd_hold = rd_word;
            end else begin
                st_d.dout = st_q.rd_hold[HALF_W-1:0];
            end
        end
        if (sync_hit) begin
            st_d.phase = PH_UPPER;
        end else if (wr_ev || rd_ev) begin
            st_d.phase = (st_q.phase == PH_UPPER) ? PH_LOWER : PH_UPPER;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_UPPER, rd_hold: '0, dout: '0};
        else        st_q <= st_d;
    end

    assign bus_dout = st_q.dout;

    p_sync_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> st_q.phase == PH_UPPER);
    p_read_advances_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev && !wr_ev && !sync_hit) |=> st_q.phase != $past(st_q.phase));
    p_dout_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ev |=> $stable(bus_dout));
endmodule

// File: tb/test_nine_bit_bus_rx.sv
module test_nine_bit_bus_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_n = 1'b1;
    logic        bus_rd_n = 1'b1;
    logic        bus_rs = 1'b0;
    logic [8:0]  bus_din = '0;
    logic [8:0]  bus_dout;
    logic [17:0] rd_word = '0;
    logic        word_valid;
    logic [17:0] word_data;
    logic        word_is_data;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    logic [17:0] cap_word = '0;
    logic        cap_tag = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    nine_bit_bus_rx i_nine_bit_bus_rx (
        .clk(clk), .rst_n(rst_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .bus_rs(bus_rs), .bus_din(bus_din), .bus_dout(bus_dout),
        .rd_word(rd_word), .word_valid(word_valid), .word_data(word_data),
        .word_is_data(word_is_data)
    );

    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            pulses   <= pulses + 1;
            cap_word <= word_data;
            cap_tag  <= word_is_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic rs, input logic [8:0] d, input int low = 3);
        @(negedge clk);
        bus_rs = rs; bus_din = d; bus_wr_n = 1'b0;
        repeat (low) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic do_read(output logic [8:0] got);
        @(negedge clk);
        bus_rd_n = 1'b0;
        repeat (5) @(negedge clk);
        got = bus_dout;
        bus_rd_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic zeros(input int n);
        for (int k = 0; k < n; k++) do_write(1'b0, 9'h000);
    endtask

    // {expect_pulse, rs, first half, second half}
    localparam logic [19:0] VEC [7] = '{
        {1'b1, 1'b1, 9'h1FF, 9'h000},
        {1'b1, 1'b1, 9'h000, 9'h1FF},
        {1'b1, 1'b1, 9'h155, 9'h0AA},
        {1'b1, 1'b0, 9'h000, 9'h02C},
        {1'b0, 1'b0, 9'h000, 9'h000},
        {1'b1, 1'b0, 9'h100, 9'h000},
        {1'b1, 1'b1, 9'h000, 9'h000}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p0;
        logic [8:0] got;
        logic [17:0] rdw;

        repeat (4) @(negedge clk);
        chk(word_valid == 1'b0, "R1 valid in reset", 32'(word_valid), 0);
        chk(bus_dout == 9'h0, "R1 dout in reset", 32'(bus_dout), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5 R8: initial sync sequence produces nothing
        p0 = pulses;
        zeros(4);
        chk(pulses == p0, "R8 sync writes silent", 32'(pulses - p0), 0);

        // table walk: R2 R3 R4 R8
        foreach (VEC[i]) begin
            p0 = pulses;
            do_write(VEC[i][18], VEC[i][17:9]);
            chk(pulses == p0, "R4 upper half silent", 32'(pulses - p0), 0);
            do_write(VEC[i][18], VEC[i][8:0]);
            chk(pulses - p0 == int'(VEC[i][19]), "R3 R8 pulse count",
                32'(pulses - p0), 32'(VEC[i][19]));
            if (VEC[i][19]) begin
                chk(cap_word == VEC[i][17:0], "R2 word", 32'(cap_word), 32'(VEC[i][17:0]));
                chk(cap_tag == VEC[i][18], "R3 tag", 32'(cap_tag), 32'(VEC[i][18]));
            end
        end

        // R5: stray half knocks the phase out, four zeros recover it
        do_write(1'b1, 9'h0AB);
        p0 = pulses;
        zeros(4);
        chk(pulses - p0 == 1, "R5 stray half flushed", 32'(pulses - p0), 1);
        chk(cap_word == 18'h15600, "R5 flushed word", 32'(cap_word), 32'h15600);
        do_write(1'b1, 9'h001);
        do_write(1'b1, 9'h002);
        chk(cap_word == 18'h00202, "R5 realigned word", 32'(cap_word), 32'h00202);

        // R6: three zeros then a data write do not resync
        zeros(3);
        p0 = pulses;
        do_write(1'b1, 9'h055);
        chk(pulses - p0 == 1, "R6 run broken, write is lower", 32'(pulses - p0), 1);
        chk(cap_word == 18'h00055, "R6 word", 32'(cap_word), 32'h00055);
        chk(cap_tag == 1'b1, "R6 tag", 32'(cap_tag), 1);
        zeros(4);

        // R7: a read inside the zero run cancels it
        zeros(3);
        do_read(got);
        zeros(1);
        p0 = pulses;
        do_write(1'b1, 9'h00A);
        chk(pulses - p0 == 1, "R7 run cleared by read", 32'(pulses - p0), 1);
        chk(cap_word == 18'h0000A, "R7 word", 32'(cap_word), 32'h0000A);
        do_write(1'b1, 9'h00B);
        zeros(4);
        zeros(4);

        // R9: read halves, lower half from captured word
        rdw = 18'h2A5C3;
        rd_word = rdw;
        do_read(got);
        chk(got == rdw[17:9], "R9 upper read half", 32'(got), 32'(rdw[17:9]));
        rd_word = 18'h0;
        do_read(got);
        chk(got == rdw[8:0], "R9 lower read half", 32'(got), 32'(rdw[8:0]));

        // R10: a single read shifts the write phase
        do_read(got);
        p0 = pulses;
        do_write(1'b1, 9'h033);
        chk(pulses - p0 == 1, "R10 read advanced phase", 32'(pulses - p0), 1);
        do_write(1'b1, 9'h011);
        do_write(1'b1, 9'h022);
        chk(cap_word == 18'h02222, "R10 word after shift", 32'(cap_word), 32'h02222);

        // R11: long strobes are acted on once
        p0 = pulses;
        do_write(1'b1, 9'h0F0, 30);
        do_write(1'b0, 9'h00F, 30);
        chk(pulses - p0 == 1, "R11 long strobe pair", 32'(pulses - p0), 1);
        chk(cap_word == 18'h1E00F, "R11 word", 32'(cap_word), 32'h1E00F);
        chk(cap_tag == 1'b0, "R11 tag", 32'(cap_tag), 0);

        finish_run();
    end
endmodule